// File: doc/BRIEF.md
# Half-Word Logical Shifter Unit

This combinational datapath performs a logical shift on one 16-bit half of a 32-bit register. One select bit picks the operand from the upper or lower half of a source word. The shift distance is a two's-complement number taken from the low bits of a count word. A positive distance moves bits toward the most significant end, a negative one moves them toward the least significant end, and vacated positions are always filled with zeros.

The shifted half-word is written into the upper or lower half of a destination word, as chosen by a second select bit. The other half of the result is copied from the old destination value, so the surrounding register file can write all 32 bits back. The operand half and the target half can be chosen independently, and the source, count and destination may all be the same register.

Top module: `half_lshift`

## Requirements
- R1: With `src_hi`=1 the operand is `src_word[31:16]`; with `src_hi`=0 it is `src_word[15:0]`.
- R2: A negative count shifts the operand right by the count's magnitude, with zeros entering at bit 15 (0x8001 by -1 gives 0x4000; 0x8007 by -1 gives 0x4003).
- R3: A positive count shifts the operand left by the count, with zeros entering at bit 0 (0x8001 by +1 gives 0x0002).
- R4: A count of zero places the operand unchanged in the destination half.
- R5: With `dst_hi`=1 the shifted value goes to `dst_new[31:16]` and `dst_new[15:0]` equals `dst_old[15:0]`; with `dst_hi`=0 it goes to `dst_new[15:0]` and `dst_new[31:16]` equals `dst_old[31:16]`.
- R6: A count whose magnitude is 16 or more (from -32 to -16, and from +16 to +31) gives a shifted value of zero.
- R7: Only `cnt_word[5:0]` is used, read as a two's-complement value from -32 to +31. Bits 31:6 have no effect.
- R8: A count of -15 moves operand bit 15 to bit 0 and clears all other bits (0xA001 gives 0x0001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_word | input | 32 | Register that holds the operand half |
| src_hi | input | 1 | 1 selects the upper half of src_word as the operand |
| cnt_word | input | 32 | Register whose low 6 bits give the signed shift count |
| dst_old | input | 32 | Previous value of the destination register |
| dst_hi | input | 1 | 1 writes the result into the upper half |
| dst_new | output | 32 | Merged destination value |

## Verification
For every input combination, the assertions check three things. The untouched half always equals the old destination value. A zero count passes the operand through unchanged. Any count of magnitude 16 or more gives zero. They also check the zero-fill edges: bit 15 is clear after any right shift and bit 0 is clear after any left shift. The exact shifted values are shown only by the bench scenarios. These cover the specific examples given in the requirements, a sweep of all 64 count codes against an independent bit-level model, and the fact that count bits above bit 5 have no effect.

// File: rtl/half_lshift.sv
module half_lshift #(
  parameter int HALF_W   = 16,
  parameter int CNT_BITS = 6
) (
  input  logic [2*HALF_W-1:0] src_word,
  input  logic                src_hi,
  input  logic [2*HALF_W-1:0] cnt_word,
  input  logic [2*HALF_W-1:0] dst_old,
  input  logic                dst_hi,
  output logic [2*HALF_W-1:0] dst_new
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [CNT_BITS:0] LIMIT = (CNT_BITS+1)'(HALF_W);

  logic [HALF_W-1:0]   operand;
  logic [CNT_BITS-1:0] cnt;
  logic [CNT_BITS-1:0] mag;
  logic                go_right;
  logic                too_far;
  logic [HALF_W-1:0]   shifted;
  logic                unused_cnt_hi;

  assign unused_cnt_hi = ^cnt_word[WORD_W-1:CNT_BITS];

  assign operand  = src_hi ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];
  assign cnt      = cnt_word[CNT_BITS-1:0];
  assign go_right = cnt[CNT_BITS-1];
  assign mag      = go_right ? (~cnt + 1'b1) : cnt;
  assign too_far  = {1'b0, mag} >= LIMIT;

  always_comb begin
    if (too_far)       shifted = '0;
    else if (go_right) shifted = operand >> mag;
    else               shifted = operand << mag;
  end

  assign dst_new = dst_hi ? {shifted, dst_old[HALF_W-1:0]}
                          : {dst_old[WORD_W-1:HALF_W], shifted};
endmodule

// File: rtl/half_lshift_chk.sv
module half_lshift_chk #(
  parameter int HALF_W   = 16,
  parameter int CNT_BITS = 6
) (
  input logic [2*HALF_W-1:0] src_word,
  input logic                src_hi,
  input logic [2*HALF_W-1:0] cnt_word,
  input logic [2*HALF_W-1:0] dst_old,
  input logic                dst_hi,
  input logic [2*HALF_W-1:0] dst_new
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] op_h, res_h, keep_new, keep_old;
  int c;

  always_comb begin
    op_h     = src_hi ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];
    res_h    = dst_hi ? dst_new[WORD_W-1:HALF_W] : dst_new[HALF_W-1:0];
    keep_new = dst_hi ? dst_new[HALF_W-1:0] : dst_new[WORD_W-1:HALF_W];
    keep_old = dst_hi ? dst_old[HALF_W-1:0] : dst_old[WORD_W-1:HALF_W];
    c        = int'($signed(cnt_word[CNT_BITS-1:0]));
    if (!$isunknown({src_word, src_hi, cnt_word, dst_old, dst_hi})) begin
      p_other_half_kept_r5: assert (keep_new == keep_old);
      p_zero_count_pass_r4: assert (c != 0 || res_h == op_h);
      p_far_count_zero_r6:  assert (!(c >= HALF_W || c <= -HALF_W) || res_h == '0);
      p_right_msb_clear_r2: assert (c >= 0 || res_h[HALF_W-1] == 1'b0);
      p_left_lsb_clear_r3:  assert (c <= 0 || res_h[0] == 1'b0);
    end
  end
endmodule

bind half_lshift half_lshift_chk #(.HALF_W(HALF_W), .CNT_BITS(CNT_BITS)) u_chk (
  .src_word(src_word), .src_hi(src_hi), .cnt_word(cnt_word),
  .dst_old(dst_old), .dst_hi(dst_hi), .dst_new(dst_new)
);

// File: tb/half_lshift_bench.sv
module half_lshift_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_word, cnt_word, dst_old, dst_new;
  logic src_hi, dst_hi;
  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  half_lshift u_half_lshift (
    .src_word(src_word), .src_hi(src_hi), .cnt_word(cnt_word),
    .dst_old(dst_old), .dst_hi(dst_hi), .dst_new(dst_new)
  );

  function automatic logic [15:0] model(input logic [15:0] op, input int c);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      int j = i - c;
      if (j >= 0 && j < 16) r[i] = op[j];
    end
    return r;
  endfunction

  task automatic apply(input logic [31:0] s, input logic sh, input logic [31:0] cw,
                       input logic [31:0] od, input logic dh,
                       input logic [31:0] exp, input string req);
    @(negedge clk);
    src_word = s; src_hi = sh; cnt_word = cw; dst_old = od; dst_hi = dh;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (dst_new !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, dst_new, exp);
    end
  endtask

  function automatic logic [31:0] cnt_of(input int c);
    return {16'h0, 16'(c)};
  endfunction

  task automatic t_reset;
    apply(32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R5 idle");
  endtask

  task automatic t_right;
    apply(32'h00008001, 0, cnt_of(-1), 32'h00008001, 0, 32'h00004000, "R2");
    apply(32'h00008007, 0, cnt_of(-1), 32'h00008007, 0, 32'h00004003, "R2");
    apply(32'h80010000, 1, cnt_of(-1), 32'h80010000, 0, 32'h80014000, "R1");
    apply(32'h80070000, 1, cnt_of(-1), 32'h80070000, 1, 32'h40030000, "R5");
    apply(32'h00008001, 0, cnt_of(-1), 32'h00008001, 1, 32'h40008001, "R5");
  endtask

  task automatic t_fifteen;
    apply(32'hA0010000, 1, cnt_of(-15), 32'hA0010000, 0, 32'hA0010001, "R8");
    apply(32'h00009003, 0, cnt_of(-15), 32'h00009003, 1, 32'h00019003, "R8");
    apply(32'h00007FFF, 0, cnt_of(-15), 32'h00007FFF, 0, 32'h00000000, "R8");
  endtask

  task automatic t_zero_count;
    apply(32'h00050005, 0, cnt_of(0), 32'h00050005, 1, 32'h00050005, "R4");
    apply(32'hBEEF1234, 1, cnt_of(0), 32'h11112222, 0, 32'h1111BEEF, "R4");
  endtask

  task automatic t_left;
    apply(32'h00008001, 0, cnt_of(1), 32'hFFFF0000, 0, 32'hFFFF0002, "R3");
    apply(32'h00000001, 0, cnt_of(4), 32'h00000000, 1, 32'h00100000, "R3");
    apply(32'h00010000, 1, cnt_of(15), 32'h0000CAFE, 1, 32'h8000CAFE, "R3");
  endtask

  task automatic t_far;
    apply(32'hB0010001, 1, cnt_of(-16), 32'hB0010001, 0, 32'hB0010000, "R6");
    apply(32'hE0010000, 1, cnt_of(-16), 32'hE0010000, 1, 32'h00000000, "R6");
    apply(32'h0000FFFF, 0, cnt_of(16),  32'h12345678, 0, 32'h12340000, "R6");
    apply(32'h0000FFFF, 0, cnt_of(31),  32'h12345678, 1, 32'h00005678, "R6");
    apply(32'h0000FFFF, 0, cnt_of(-32), 32'h12345678, 0, 32'h12340000, "R6");
  endtask

  task automatic t_count_bits;
    apply(32'h00008001, 0, 32'h1234FFC1, 32'h0, 0, 32'h00000002, "R7");
    apply(32'h00008001, 0, 32'hFFFF0040, 32'h0, 0, 32'h00008001, "R7");
    apply(32'h00008001, 0, 32'h0000003F, 32'h0, 0, 32'h00004000, "R7");
  endtask

  task automatic t_sweep;
    for (int c = -32; c < 32; c++) begin
      logic [15:0] e = model(16'hC35A, c);
      apply(32'hC35A0000, 1, {26'h2AAAAAA, 6'(c)}, 32'h5A5A5A5A, 0,
            {16'h5A5A, e}, "R7 sweep");
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    src_word = '0; src_hi = 0; cnt_word = '0; dst_old = '0; dst_hi = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset;
    t_right;
    t_fifteen;
    t_zero_count;
    t_left;
    t_far;
    t_count_bits;
    t_sweep;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule